// File: doc/BRIEF.md
# Scanline-Timed Repeating Interrupt Generator

This block raises an interrupt at a chosen scanline and horizontal cycle position inside the next video frame, then raises it again once per scanline for a chosen number of times. It keeps its own free-running cycle counter and stores the counter value whenever a frame-start strobe arrives. A schedule request carries a repeat count, a line number and a cycle offset. The block works out the first event time from the stored frame start, and chains each later event exactly one line period after the one before.

Two video timing modes are supported. The 60 Hz mode has 263 lines per frame and the 50 Hz mode has 314. The frame and line periods are integer quotients of the clock frequency parameter. Every firing produces a one-cycle pulse and sets a sticky bit 10 in a status register. Software clears that bit through a per-bit clear input.

Top module: `scanirq_gen`

## Requirements
- R1: After reset, `irq_stat_o` is all zero, `irq_pulse_o` is low, and no event is pending.
- R2: In mode 0 (60 Hz, `pal_mode_i`=0) the frame period is CLK_HZ/60 cycles and the line period is that value divided by 263. In mode 1 (50 Hz) the frame period is CLK_HZ/50 and the line period is that value divided by 314. All divisions are integer divisions.
- R3: Let F be the cycle in which `frame_start_i` was last high before a request. The first firing is due at F + D, where D = frame + line_no*frame/lines + offset. `irq_pulse_o` is high in the cycle D+1 cycles after the strobe cycle.
- R4: A request with count N ≥ 1 yields N firings, each one line period after the previous firing. A count of 0 yields a single firing.
- R5: After the last firing of a chain, no further pulse occurs until a new request arrives.
- R6: A new request cancels any pending chain. It reloads the count and event time, so the cancelled chain never fires.
- R7: Each firing sets status bit 10 in the same cycle as `irq_pulse_o`. The bit stays set until `stat_clr_i[10]` is high.
- R8: When a firing and `stat_clr_i[10]` occur in the same cycle, bit 10 ends up set.
- R9: Status bits other than 10 always read 0, whatever `stat_clr_i` holds.
- R10: The timing mode is sampled in the request cycle. A later change of `pal_mode_i` does not move an armed chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame-start strobe; latches the cycle counter |
| sched_req_i | input | 1 | Schedule request strobe |
| sched_count_i | input | CNT_W | Number of firings (0 acts as 1) |
| sched_line_i | input | LINE_W | Scanline number of the first firing |
| sched_xoff_i | input | XOFF_W | Cycle offset added to the first firing |
| pal_mode_i | input | 1 | Timing mode: 0 = 60 Hz/263 lines, 1 = 50 Hz/314 lines |
| stat_clr_i | input | STAT_W | Per-bit status clear |
| irq_pulse_o | output | 1 | One-cycle pulse per firing |
| irq_stat_o | output | STAT_W | Interrupt status; only bit 10 can be set |

## Verification
The event is detected combinationally in the cycle whose counter value equals F + D, and it is registered once. As a result, the pulse and status bit appear D+1 cycles after the frame strobe cycle. Each later pulse follows the previous one by exactly one line period. The bench counts falling edges from the strobe cycle and compares each observed pulse position with that arithmetic. The stretch after the final expected pulse is watched for stray pulses. For the set/clear collision, the clear is driven in the cycle just before the pulse becomes visible, because the set lands at the edge that ends that cycle.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
  typedef enum logic {
    VMODE_60 = 1'b0,
    VMODE_50 = 1'b1
  } vmode_e;

  localparam int unsigned LINES_60 = 263;
  localparam int unsigned LINES_50 = 314;
  localparam int unsigned RATE_60  = 60;
  localparam int unsigned RATE_50  = 50;
endpackage

// File: rtl/scanirq_timebase.sv
module scanirq_timebase #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_i,
  output logic [TIME_W-1:0] now_o,
  output logic [TIME_W-1:0] fstart_o
);
  logic [TIME_W-1:0] cyc_q;
  logic [TIME_W-1:0] fstart_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q    <= '0;
      fstart_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (frame_start_i) fstart_q <= cyc_q;
    end
  end

  assign now_o    = cyc_q;
  assign fstart_o = fstart_q;

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cyc_q == $past(cyc_q) + 1'b1);
endmodule

// File: rtl/scanirq_calc.sv
module scanirq_calc
  import scanirq_pkg::*;
#(
  parameter int CLK_HZ = 33868800,
  parameter int TIME_W = 32,
  parameter int LINE_W = 9,
  parameter int XOFF_W = 16
) (
  input  vmode_e            mode_i,
  input  logic [LINE_W-1:0] line_no_i,
  input  logic [XOFF_W-1:0] xoff_i,
  output logic [TIME_W-1:0] first_dly_o,
  output logic [TIME_W-1:0] line_per_o
);
  localparam int PW = TIME_W + LINE_W;
  localparam logic [TIME_W-1:0] FRAME60 = TIME_W'(CLK_HZ / RATE_60);
  localparam logic [TIME_W-1:0] FRAME50 = TIME_W'(CLK_HZ / RATE_50);
  localparam logic [TIME_W-1:0] LINE60  = TIME_W'((CLK_HZ / RATE_60) / LINES_60);
  localparam logic [TIME_W-1:0] LINE50  = TIME_W'((CLK_HZ / RATE_50) / LINES_50);

  logic [TIME_W-1:0] frame_sel;
  logic [PW-1:0]     lines_sel;
  logic [PW-1:0]     prod;
  logic [PW-1:0]     quot;

  always_comb begin
    if (mode_i == VMODE_50) begin
      frame_sel  = FRAME50;
      lines_sel  = PW'(LINES_50);
      line_per_o = LINE50;
    end else begin
      frame_sel  = FRAME60;
      lines_sel  = PW'(LINES_60);
      line_per_o = LINE60;
    end
    prod        = PW'(line_no_i) * PW'(frame_sel);
    quot        = prod / lines_sel;
    first_dly_o = frame_sel + TIME_W'(quot) + TIME_W'(xoff_i);
  end
endmodule

// File: rtl/scanirq_chain.sv
module scanirq_chain #(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] fstart_i,
  input  logic              req_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [TIME_W-1:0] first_dly_i,
  input  logic [TIME_W-1:0] line_per_i,
  output logic              fire_o
);
  logic              pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TIME_W-1:0] base_q;
  logic [TIME_W-1:0] dly_q;
  logic [TIME_W-1:0] line_q;
  logic [TIME_W-1:0] elapsed;

  assign elapsed = now_i - base_q;
  assign fire_o  = pend_q && !req_i && (elapsed >= dly_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      dly_q  <= '0;
      line_q <= '0;
    end else if (req_i) begin
      pend_q <= 1'b1;
      cnt_q  <= count_i;
      base_q <= fstart_i;
      dly_q  <= first_dly_i;
      line_q <= line_per_i;
    end else if (fire_o) begin
      if (cnt_q > CNT_W'(1)) begin
        cnt_q <= cnt_q - 1'b1;
        dly_q <= dly_q + line_q;
      end else begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> !pend_q);
  p_req_arms_r6: assert property (@(posedge clk) disable iff (rst)
    req_i |=> pend_q && cnt_q == $past(count_i) && dly_q == $past(first_dly_i));
  p_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (fire_o && cnt_q > CNT_W'(1)) |=> pend_q && dly_q == $past(dly_q) + $past(line_q));
  p_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (fire_o && cnt_q <= CNT_W'(1)) |=> !pend_q);
  p_mode_held_r10: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> $stable(line_q));
endmodule

// File: rtl/scanirq_gen.sv
module scanirq_gen
  import scanirq_pkg::*;
#(
  parameter int CLK_HZ  = 33868800,
  parameter int TIME_W  = 32,
  parameter int CNT_W   = 8,
  parameter int LINE_W  = 9,
  parameter int XOFF_W  = 16,
  parameter int STAT_W  = 16,
  parameter int IRQ_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_i,
  input  logic              sched_req_i,
  input  logic [CNT_W-1:0]  sched_count_i,
  input  logic [LINE_W-1:0] sched_line_i,
  input  logic [XOFF_W-1:0] sched_xoff_i,
  input  logic              pal_mode_i,
  input  logic [STAT_W-1:0] stat_clr_i,
  output logic              irq_pulse_o,
  output logic [STAT_W-1:0] irq_stat_o
);
  logic [TIME_W-1:0] now;
  logic [TIME_W-1:0] fstart;
  logic [TIME_W-1:0] first_dly;
  logic [TIME_W-1:0] line_per;
  logic              fire_now;
  logic              pulse_q;
  logic [STAT_W-1:0] stat_q;
  vmode_e            mode;

  assign mode = vmode_e'(pal_mode_i);

  scanirq_timebase #(.TIME_W(TIME_W)) u_tb (
    .clk(clk), .rst(rst), .frame_start_i(frame_start_i),
    .now_o(now), .fstart_o(fstart)
  );

  scanirq_calc #(
    .CLK_HZ(CLK_HZ), .TIME_W(TIME_W), .LINE_W(LINE_W), .XOFF_W(XOFF_W)
  ) u_calc (
    .mode_i(mode), .line_no_i(sched_line_i), .xoff_i(sched_xoff_i),
    .first_dly_o(first_dly), .line_per_o(line_per)
  );

  scanirq_chain #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst(rst), .now_i(now), .fstart_i(fstart),
    .req_i(sched_req_i), .count_i(sched_count_i),
    .first_dly_i(first_dly), .line_per_i(line_per), .fire_o(fire_now)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= fire_now;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == IRQ_BIT) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)           stat_q[b] <= 1'b0;
        else if (fire_now) stat_q[b] <= 1'b1;
        else if (stat_clr_i[b]) stat_q[b] <= 1'b0;
      end
    end else begin : g_zero
      assign stat_q[b] = 1'b0;
    end
  end

  assign irq_pulse_o = pulse_q;
  assign irq_stat_o  = stat_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> irq_stat_o == '0 && !irq_pulse_o);
  p_pulse_sets_r7: assert property (@(posedge clk) disable iff (rst)
    irq_pulse_o |-> irq_stat_o[IRQ_BIT]);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_stat_o[IRQ_BIT] && !stat_clr_i[IRQ_BIT]) |=> irq_stat_o[IRQ_BIT]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_clr_i[IRQ_BIT] && !fire_now) |=> !irq_stat_o[IRQ_BIT]);
  p_others_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_stat_o) <= 1);
endmodule

// File: tb/test_scanirq_gen.sv
module test_scanirq_gen;
  localparam int CLK_HZ = 314000;
  localparam int STAT_W = 16;
  localparam int IRQB   = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_start;
  logic        req;
  logic [7:0]  cnt;
  logic [8:0]  line_no;
  logic [15:0] xoff;
  logic        pal;
  logic [STAT_W-1:0] clr;
  logic        pulse;
  logic [STAT_W-1:0] stat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  scanirq_gen #(.CLK_HZ(CLK_HZ)) i_scanirq_gen (
    .clk(clk), .rst(rst), .frame_start_i(frame_start), .sched_req_i(req),
    .sched_count_i(cnt), .sched_line_i(line_no), .sched_xoff_i(xoff),
    .pal_mode_i(pal), .stat_clr_i(clr), .irq_pulse_o(pulse), .irq_stat_o(stat)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr = '1;
    @(negedge clk); clr = '0;
  endtask

  // Strobe frame start, request at n=5, and watch pulses.
  task automatic run_sched(input string tag, input logic md, input int y, input int x,
                           input int count, input int first, input int lp,
                           input int num, input bit cancel);
    int nf = 0;
    int last = first + lp * (num + 3);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int n = 1; n <= last; n++) begin
      if (n == 5) begin
        req = 1'b1; pal = md; line_no = 9'(y);
        xoff = cancel ? 16'd0 : 16'(x);
        cnt  = cancel ? 8'd5 : 8'(count);
      end else if (n == 6) begin
        if (cancel) begin xoff = 16'(x); cnt = 8'(count); end
        else req = 1'b0;
      end else if (n == 7) begin
        req = 1'b0; pal = ~md;   // R10: later mode change must not matter
      end
      if (pulse) begin
        check({tag, " pulse position"}, n, first + nf * lp);
        check({tag, " R7 status set with pulse"}, stat[IRQB], 1);
        nf++;
      end
      @(negedge clk);
    end
    check({tag, " pulse count"}, nf, num);
    pal = 1'b0;
    clear_all();
  endtask

  task automatic t_reset();
    check("R1 status after reset", stat, 0);
    check("R1 pulse after reset", pulse, 0);
    repeat (20) @(negedge clk);
    check("R1 no pulse when idle", pulse, 0);
  endtask

  task automatic t_status();
    // 60 Hz, line 0, offset 0, single: D = 5233
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int n = 1; n <= 5250; n++) begin
      if (n == 5) begin req = 1'b1; pal = 1'b0; line_no = '0; xoff = '0; cnt = 8'd1; end
      if (n == 6) req = 1'b0;
      if (n == 5240) check("R7 bit held", stat[IRQB], 1);
      if (n == 5241) clr = 16'h0008;
      if (n == 5242) begin
        check("R9 clear of other bit no effect", stat, 16'h0400);
        clr = 16'h0400;
      end
      if (n == 5243) begin check("R7 clear drops bit", stat, 0); clr = '0; end
      @(negedge clk);
    end
    // collision: clear in the cycle whose edge applies the set
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int n = 1; n <= 5240; n++) begin
      if (n == 5) begin req = 1'b1; cnt = 8'd1; end
      if (n == 6) req = 1'b0;
      if (n == 5233) clr = 16'h0400;
      if (n == 5234) begin
        check("R8 set beats clear", stat[IRQB], 1);
        check("R8 pulse present", pulse, 1);
        clr = '0;
      end
      @(negedge clk);
    end
    clear_all();
    check("R9 other bits zero after all-ones clear", stat, 0);
  endtask

  initial begin
    rst = 1'b1; frame_start = 1'b0; req = 1'b0; cnt = '0; line_no = '0;
    xoff = '0; pal = 1'b0; clr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // R2/R3/R5: 60 Hz frame 5233, line 19
    run_sched("R3 R5 60Hz single", 1'b0, 0, 0, 1, 5234, 19, 1, 1'b0);
    // R4: 5*5233/263 = 99 -> D = 5339
    run_sched("R4 R2 60Hz chain of 3", 1'b0, 5, 7, 3, 5340, 19, 3, 1'b0);
    // R2/R10: 50 Hz frame 6280, line 20, 10*6280/314 = 200 -> D = 6483
    run_sched("R2 R10 50Hz chain of 2", 1'b1, 10, 3, 2, 6484, 20, 2, 1'b0);
    run_sched("R4 count zero", 1'b0, 0, 1, 0, 5235, 19, 1, 1'b0);
    run_sched("R6 cancel by new request", 1'b0, 0, 50, 1, 5284, 19, 1, 1'b1);
    t_status();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule